// File: doc/BRIEF.md
# Frequency Counter Gate Sequencer

This block is the control state machine for one measurement cycle of a frequency counter. It has a clock that stands for the counter's 1 MHz reference. Each automatic cycle does four things in turn. First it drives a one-cycle clear pulse to the counting chain and the timebase divider. It then opens the count gate on the clock edge that first sees a timebase strobe. The gate closes on the edge that sees the next strobe. Last, a one-cycle latch pulse copies the count into the display register. The result then stays on view for a programmable display time, and when that time runs out the next cycle starts.

The display time is a number of 0.1 s steps. Each step is timed by a prescaler of `STEP_CYCLES` clocks. A hold input freezes the display timer, so the last result can stay on view for as long as needed. In manual mode the latch stays high, so the display follows the live count. The gate follows a run level, and the counters are cleared only by a reset button. Any change of mode sends the sequencer back to its clear state, so a partial cycle is never latched.

Top module: `gate_sequencer`

## Requirements
- R1: While reset is low, and for the two clock edges after it is released, clear_o=1, gate_o=0, latch_o=0 and gate_led_n_o=1.
- R2: In automatic mode clear_o is high for exactly one clock cycle. It is then low while the sequencer waits for a timebase strobe, and gate_o stays 0 during that wait.
- R3: In automatic mode gate_o rises on the clock edge that samples tb_edge_i=1 while the sequencer is waiting. It falls on the edge that next samples tb_edge_i=1.
- R4: latch_o is high for exactly one clock cycle. That cycle starts on the edge where gate_o falls.
- R5: clear_o rises max(disp_steps_i,1)*STEP_CYCLES clock edges after the edge that ends the latch pulse. disp_steps_i is an unsigned step count, and a value of 0 counts as 1.
- R6: Each clock edge that samples hold_i=1 during the display time adds one cycle to the time left. The timer resumes its count when hold_i returns to 0.
- R7: gate_led_n_o is always the inverse of gate_o.
- R8: In manual mode latch_o is held at 1, and gate_o takes the value that run_i had on the previous clock edge.
- R9: In manual mode clear_o takes the value that reset_btn_i had on the previous clock edge, and tb_edge_i has no effect.
- R10: On the edge that samples a new value of manual_i, the sequencer enters its clear state: clear_o=1, gate_o=0, latch_o=0. On the next edge it enters the selected mode.
- R11: In automatic mode a tb_edge_i strobe that arrives during the clear cycle or the display time leaves gate_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (1 MHz in use) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_edge_i | input | 1 | One-cycle strobe marking a timebase transition |
| manual_i | input | 1 | 1 selects manual mode |
| run_i | input | 1 | Manual gate level: 1 open, 0 closed |
| reset_btn_i | input | 1 | Manual counter clear request |
| hold_i | input | 1 | Freezes the display timer |
| disp_steps_i | input | STEPS_W | Display time in 0.1 s steps |
| clear_o | output | 1 | Counter and timebase clear |
| gate_o | output | 1 | Count gate, high while open |
| latch_o | output | 1 | Display register load strobe |
| gate_led_n_o | output | 1 | Active-low gate indicator |

## Verification
The timing of each result follows from the inputs as they were sampled on clock edges. Gate changes, latch and all manual-mode outputs show up on the first edge that samples their cause. The second clear after a mode switch follows one edge later. The end of the display time comes max(steps,1)*STEP_CYCLES edges after the latch pulse, plus one edge for each sampled hold. The bench drives every input on a falling edge and reads outputs on the next falling edge. It counts edges explicitly, so each expectation is checked in exactly the cycle it falls due, and the cycles on either side are checked as well. Random gap lengths, step counts, hold lengths and manual run/button patterns are checked against these formulas. Directed cases cover a step count of zero, the maximum of 100, stray strobes, and mode switches while the gate is open.

// File: rtl/gseq_pkg.sv
package gseq_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR = 3'd0,
    ST_ARM   = 3'd1,
    ST_OPEN  = 3'd2,
    ST_LATCH = 3'd3,
    ST_SHOW  = 3'd4,
    ST_MAN   = 3'd5
  } gseq_state_e;
endpackage

// File: rtl/gseq_rst_sync.sv
module gseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/gseq_disp_timer.sv
module gseq_disp_timer #(
  parameter int STEP_CYCLES = 100000,
  parameter int STEPS_W     = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               hold,
  input  logic [STEPS_W-1:0] steps,
  output logic               expired
);
  localparam int PRE_W = $clog2(STEP_CYCLES + 1);

  logic [PRE_W-1:0]   pre_q, pre_d;
  logic [STEPS_W-1:0] step_q, step_d;
  logic [STEPS_W-1:0] steps_eff;
  logic               pre_wrap, last_step, tick_en;

  assign steps_eff = (steps == '0) ? STEPS_W'(1) : steps;
  assign pre_wrap  = (pre_q == PRE_W'(STEP_CYCLES - 1));
  assign last_step = (({1'b0, step_q} + (STEPS_W+1)'(1)) >= {1'b0, steps_eff});
  assign tick_en   = run_en && !hold;
  assign expired   = tick_en && pre_wrap && last_step;

  always_comb begin
    pre_d  = pre_q;
    step_d = step_q;
    if (!run_en) begin
      pre_d  = '0;
      step_d = '0;
    end else if (tick_en) begin
      if (pre_wrap) begin
        pre_d  = '0;
        step_d = step_q + STEPS_W'(1);
      end else begin
        pre_d  = pre_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      step_q <= '0;
    end else begin
      pre_q  <= pre_d;
      step_q <= step_d;
    end
  end
endmodule

// File: rtl/gseq_fsm.sv
module gseq_fsm
  import gseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic manual_i,
  input  logic tb_edge_i,
  input  logic run_i,
  input  logic btn_i,
  input  logic expired,
  output logic mode_man,
  output logic timer_en,
  output logic clear_o,
  output logic gate_o,
  output logic latch_o
);
  gseq_state_e state_q, state_d;
  logic        mode_q, run_q, btn_q;

  always_comb begin
    state_d = state_q;
    if (manual_i != mode_q) begin
      state_d = ST_CLEAR;
    end else begin
      case (state_q)
        ST_CLEAR: state_d = mode_q ? ST_MAN : ST_ARM;
        ST_ARM:   if (tb_edge_i) state_d = ST_OPEN;
        ST_OPEN:  if (tb_edge_i) state_d = ST_LATCH;
        ST_LATCH: state_d = ST_SHOW;
        ST_SHOW:  if (expired) state_d = ST_CLEAR;
        ST_MAN:   state_d = ST_MAN;
        default:  state_d = ST_CLEAR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CLEAR;
      mode_q  <= 1'b0;
      run_q   <= 1'b0;
      btn_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= manual_i;
      run_q   <= run_i;
      btn_q   <= btn_i;
    end
  end

  assign mode_man = mode_q;
  assign timer_en = (state_q == ST_SHOW);
  assign clear_o  = (state_q == ST_CLEAR) || ((state_q == ST_MAN) && btn_q);
  assign gate_o   = (state_q == ST_OPEN)  || ((state_q == ST_MAN) && run_q);
  assign latch_o  = (state_q == ST_LATCH) || (state_q == ST_MAN);
endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer #(
  parameter int STEP_CYCLES = 100000,
  parameter int STEPS_W     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tb_edge_i,
  input  logic               manual_i,
  input  logic               run_i,
  input  logic               reset_btn_i,
  input  logic               hold_i,
  input  logic [STEPS_W-1:0] disp_steps_i,
  output logic               clear_o,
  output logic               gate_o,
  output logic               latch_o,
  output logic               gate_led_n_o
);
  logic rst_n_s;
  logic mode_man;
  logic timer_en;
  logic expired;

  gseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  gseq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .manual_i  (manual_i),
    .tb_edge_i (tb_edge_i),
    .run_i     (run_i),
    .btn_i     (reset_btn_i),
    .expired   (expired),
    .mode_man  (mode_man),
    .timer_en  (timer_en),
    .clear_o   (clear_o),
    .gate_o    (gate_o),
    .latch_o   (latch_o)
  );

  gseq_disp_timer #(.STEP_CYCLES(STEP_CYCLES), .STEPS_W(STEPS_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .run_en  (timer_en),
    .hold    (hold_i),
    .steps   (disp_steps_i),
    .expired (expired)
  );

  assign gate_led_n_o = ~gate_o;
endmodule

// File: rtl/gseq_checker.sv
module gseq_checker (
  input logic clk,
  input logic rst_n,
  input logic tb_edge_i,
  input logic manual_i,
  input logic mode_man,
  input logic clear_o,
  input logic gate_o,
  input logic latch_o
);
  AST_LATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_o && !mode_man) |=> !latch_o); // R4

  AST_LATCH_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(latch_o) && !mode_man) |-> $past(gate_o)); // R4

  AST_GATE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_o) && !mode_man) |-> $past(tb_edge_i)); // R3

  AST_NO_GATE_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_man |-> !(gate_o && clear_o)); // R2

  AST_MANUAL_LATCH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_man && gate_o) |-> latch_o); // R8

  AST_SWITCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (manual_i != mode_man) |=> (clear_o && !gate_o)); // R10
endmodule

bind gate_sequencer gseq_checker u_gseq_checker (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .tb_edge_i (tb_edge_i),
  .manual_i  (manual_i),
  .mode_man  (mode_man),
  .clear_o   (clear_o),
  .gate_o    (gate_o),
  .latch_o   (latch_o)
);

// File: tb/test_gate_sequencer.sv
module test_gate_sequencer;
  localparam int P  = 4;
  localparam int SW = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic tb_edge, manual, run, btn, hold;
  logic [SW-1:0] steps;
  logic clear_w, gate_w, latch_w, led_n_w;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gate_sequencer #(.STEP_CYCLES(P), .STEPS_W(SW)) i_gate_sequencer (
    .clk(clk), .rst_n(rst_n), .tb_edge_i(tb_edge), .manual_i(manual),
    .run_i(run), .reset_btn_i(btn), .hold_i(hold), .disp_steps_i(steps),
    .clear_o(clear_w), .gate_o(gate_w), .latch_o(latch_w), .gate_led_n_o(led_n_w)
  );

  function automatic int disp_cycles(input int s);
    return ((s == 0) ? 1 : s) * P;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic outs(input string tag, input int c, input int g, input int l);
    chk({tag, " clear"}, clear_w, c);
    chk({tag, " gate"}, gate_w, g);
    chk({tag, " latch"}, latch_w, l);
    chk("R7 led", led_n_w, !gate_w);
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Starts and ends with the sequencer waiting for a strobe.
  task automatic auto_cycle(input int gap, input int open_len, input int s,
                            input int hold_len, input bit stray);
    steps = SW'(s);
    for (int i = 0; i < gap; i++) begin
      cyc();
      outs("R2 wait", 0, 0, 0);
    end
    tb_edge = 1'b1; cyc(); tb_edge = 1'b0;
    outs("R3 open", 0, 1, 0);
    for (int i = 0; i < open_len; i++) begin
      cyc();
      outs("R3 held", 0, 1, 0);
    end
    tb_edge = 1'b1; cyc(); tb_edge = 1'b0;
    outs("R4 close", 0, 0, 1);
    cyc();
    outs("R4 end", 0, 0, 0);
    for (int i = 0; i < disp_cycles(s) + hold_len - 1; i++) begin
      hold = (i >= 1 && i <= hold_len);
      tb_edge = stray && (i == 0);
      cyc();
      tb_edge = 1'b0;
      outs("R6 R11 show", 0, 0, 0);
    end
    hold = 1'b0;
    cyc();
    outs("R5 expire", 1, 0, 0);
    tb_edge = stray;
    cyc();
    tb_edge = 1'b0;
    outs("R2 R11 after clear", 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end

  initial begin
    void'($urandom(32'd5151));
    rst_n = 1'b0; tb_edge = 0; manual = 0; run = 0; btn = 0; hold = 0;
    steps = SW'(1);
    repeat (3) cyc();
    outs("R1 in reset", 1, 0, 0);
    chk("R1 led", led_n_w, 1);
    tb_edge = 1'b1;
    rst_n = 1'b1;
    cyc(); outs("R1 sync 1", 1, 0, 0);
    cyc(); outs("R1 sync 2", 1, 0, 0);
    tb_edge = 1'b0;
    cyc(); outs("R2 first arm", 0, 0, 0);

    // directed corner cases
    auto_cycle(2, 3, 0, 0, 1'b1);   // zero steps counts as one
    auto_cycle(0, 0, 1, 0, 1'b0);
    auto_cycle(1, 2, 3, 7, 1'b1);   // hold stretches display
    auto_cycle(0, 1, 100, 0, 1'b0); // maximum step count

    for (int k = 0; k < 12; k++) begin
      auto_cycle(int'($urandom_range(0, 6)), int'($urandom_range(0, 9)),
                 int'($urandom_range(0, 6)), int'($urandom_range(0, 15)),
                 1'($urandom_range(0, 1)));
    end

    // manual mode
    manual = 1'b1;
    cyc(); outs("R10 to manual", 1, 0, 0);
    cyc(); outs("R8 manual idle", 0, 0, 1);
    run = 1'b1;
    cyc(); outs("R8 run", 0, 1, 1);
    tb_edge = 1'b1;
    cyc(); tb_edge = 1'b0;
    outs("R9 strobe ignored", 0, 1, 1);
    for (int k = 0; k < 40; k++) begin
      bit r = 1'($urandom_range(0, 1));
      bit b = 1'($urandom_range(0, 1));
      run = r; btn = b; tb_edge = 1'($urandom_range(0, 1));
      cyc();
      outs("R8 R9 manual random", b, r, 1);
    end
    run = 0; btn = 0; tb_edge = 0;
    cyc(); outs("R9 manual quiet", 0, 0, 1);
    btn = 1'b1;
    cyc(); btn = 1'b0;
    outs("R9 button clear", 1, 0, 1);
    cyc(); outs("R9 button released", 0, 0, 1);

    manual = 1'b0;
    run = 1'b1;
    cyc(); outs("R10 to auto", 1, 0, 0);
    cyc(); outs("R10 auto arm", 0, 0, 0);
    run = 1'b0;

    // switch while the gate is open: no latch
    tb_edge = 1'b1; cyc(); tb_edge = 1'b0;
    outs("R3 open before switch", 0, 1, 0);
    manual = 1'b1;
    cyc(); outs("R10 switch mid gate", 1, 0, 0);
    manual = 1'b0;
    cyc(); outs("R10 switch back", 1, 0, 0);
    cyc(); outs("R10 rearmed", 0, 0, 0);
    auto_cycle(3, 4, 2, 3, 1'b1);

    report();
  end
endmodule